// File: doc/BRIEF.md
# Steered Toggle-Chain Decade Counter

This block is one decimal digit built the way a discrete ripple counter is built: four toggle stages weighted 8-4-2-1, where each stage flips when its own source signal goes from high to low. Left alone, such a chain counts to sixteen. Here, steering gates mask and reselect the toggle sources so the digit only passes through 0 to 9 and then returns to 0.

Everything runs in one system clock domain. A high-to-low transition of the count-pulse input is found by comparing it with its value one cycle earlier. Inside the same cycle, the toggle it causes ripples down the chain. Each later stage sees the falling edge of its source as "old value high, new value low" and takes it as a toggle enable. The whole digit therefore settles to its next value at a single clock edge.

A carry pulse one cycle long marks the return from 9 to 0, so that a following digit can count it.

Top module: `tc_decade_top`

## Requirements
- R1: A synchronous active-high `rst` clears all four stages and the carry output to 0. While `rst` is high, the pulse input has no effect.
- R2: The count advances only when `pulse_in` is sampled high at one rising clock edge and low at the next. The new count appears on `q_out` at that second edge. In any other cycle, `q_out` holds its value.
- R3: The weight-1 stage (`q_out[0]`) toggles on every counted falling edge of `pulse_in`.
- R4: Starting from reset, successive counted edges give 1, 2, ... 9 and then 0. Codes 10 to 15 never appear on `q_out`.
- R5: The weight-8 stage (`q_out[3]`) is high only at counts 8 and 9. The weight-2 stage does not toggle on the step from 9 to 0.
- R6: `carry_out` is high for exactly one cycle, in the same cycle that `q_out` first shows 0 after 9. It is low at all other times.
- R7: Holding `pulse_in` high or low for many cycles produces at most one count per high-to-low transition.
- R8: `q_out` bit 3 carries weight 8, bit 2 weight 4, bit 1 weight 2 and bit 0 weight 1. The count 8 therefore reads as 4'b1000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| pulse_in | input | 1 | Count pulse; each high-to-low transition counts once |
| q_out | output | 4 | Stage outputs, 8-4-2-1 weighting |
| carry_out | output | 1 | One-cycle pulse on the 9 to 0 wrap |

## Verification
The hardest situation to bring about is the wrap from 9 to 0. There, the masking gate must block the weight-2 stage while the selector clears the weight-8 stage, all in the same cycle that produces the carry. A second hard case is the step from 7 to 8, where one input edge ripples through all four stages at once.

The stimulus drives more than three full decades with pulses of varying high and low lengths, so that both of these steps occur many times. It also asserts reset in mid-count, just after the count reaches 9, and then counts again from zero.

// File: rtl/tc_pkg.sv
package tc_pkg;
    localparam int STAGES  = 4;
    localparam int MODULUS = 10;
    localparam int TOP_BIT = STAGES - 1;

    typedef struct packed {
        logic pulse;
        logic carry;
    } edge_state_t;
endpackage

// File: rtl/tc_tstage.sv
module tc_tstage (
    input  logic clk,
    input  logic rst,
    input  logic tog_en,
    output logic q
);
    logic bit_d;
    logic bit_q;

    always_comb begin
        bit_d = bit_q ^ tog_en;
    end

    always_ff @(posedge clk) begin
        if (rst) bit_q <= 1'b0;
        else     bit_q <= bit_d;
    end

    assign q = bit_q;
endmodule

// File: rtl/tc_steer.sv
module tc_steer
    import tc_pkg::*;
(
    input  logic [STAGES-1:0] stage_q,
    input  logic              adv,
    output logic [STAGES-1:0] tog
);
    logic q0_new;
    logic q1_new;
    logic q2_new;
    logic src1_old;
    logic src1_new;

    always_comb begin
        // weight-1 stage: its source is the count pulse itself
        tog[0]   = adv;
        q0_new   = stage_q[0] ^ tog[0];

        // weight-2 stage: source is Q0 masked by NOT Q3
        src1_old = stage_q[0] & ~stage_q[3];
        src1_new = q0_new & ~stage_q[3];
        tog[1]   = src1_old & ~src1_new;
        q1_new   = stage_q[1] ^ tog[1];

        // weight-4 stage: source is Q1
        tog[2]   = stage_q[1] & ~q1_new;
        q2_new   = stage_q[2] ^ tog[2];

        // weight-8 stage: AND-OR selector, set on entering 8, cleared on wrap
        tog[3]   = (stage_q[2] & ~q2_new) | (stage_q[3] & stage_q[0] & ~q0_new);
    end
endmodule

// File: rtl/tc_decade_top.sv
module tc_decade_top
    import tc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              pulse_in,
    output logic [STAGES-1:0] q_out,
    output logic              carry_out
);
    edge_state_t       st_d;
    edge_state_t       st_q;
    logic              adv;
    logic [STAGES-1:0] stage_q;
    logic [STAGES-1:0] tog;

    assign adv = st_q.pulse & ~pulse_in;

    tc_steer steer_i (
        .stage_q (stage_q),
        .adv     (adv),
        .tog     (tog)
    );

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        tc_tstage stage_i (
            .clk    (clk),
            .rst    (rst),
            .tog_en (tog[i]),
            .q      (stage_q[i])
        );
    end

    always_comb begin
        st_d       = st_q;
        st_d.pulse = pulse_in;
        st_d.carry = stage_q[TOP_BIT] & tog[TOP_BIT];
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign q_out     = stage_q;
    assign carry_out = st_q.carry;

    // R4
    count_range_chk: assert property (@(posedge clk) disable iff (rst)
        stage_q < 4'(MODULUS));

    // R3
    q0_toggle_chk: assert property (@(posedge clk) disable iff (rst)
        adv |=> (stage_q[0] != $past(stage_q[0])));

    // R2
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !adv |=> $stable(stage_q));

    // R5
    q3_span_chk: assert property (@(posedge clk) disable iff (rst)
        stage_q[3] |-> (stage_q[2:1] == 2'b00));

    // R6
    carry_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        st_q.carry |-> (stage_q == '0 && $past(stage_q) == 4'd9));

    // R6
    carry_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        st_q.carry |=> !st_q.carry);
endmodule

// File: tb/tc_decade_top_tb_top.sv
module tc_decade_top_tb_top;
    localparam time CLK_PERIOD = 10ns;

    typedef struct {
        logic [3:0] cnt;
        logic       carry;
        string      tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pulse_in = 1'b0;
    logic [3:0] q_out;
    logic       carry_out;

    exp_t exp_q[$];
    int   n_checks = 0;
    int   n_fail   = 0;
    int   m_cnt    = 0;
    logic m_prev   = 1'b0;
    bit   done     = 1'b0;

    tc_decade_top dut_i (
        .clk       (clk),
        .rst       (rst),
        .pulse_in  (pulse_in),
        .q_out     (q_out),
        .carry_out (carry_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // one cycle of stimulus plus its expected result
    task automatic step(input logic pv, input logic rv);
        exp_t e;
        @(negedge clk);
        pulse_in = pv;
        rst      = rv;
        e.carry  = 1'b0;
        if (rv) begin
            m_cnt  = 0;
            m_prev = 1'b0;
            e.tag  = "R1";
        end else if (m_prev && !pv) begin
            e.carry = (m_cnt == 9);
            e.tag   = (m_cnt == 9) ? "R6" : "R3";
            m_cnt   = (m_cnt + 1) % 10;
            m_prev  = pv;
        end else begin
            e.tag  = (pv && m_prev) ? "R7" : "R2";
            m_prev = pv;
        end
        e.cnt = 4'(m_cnt);
        exp_q.push_back(e);
    endtask

    task automatic pulse(input int hi, input int lo);
        for (int i = 0; i < hi; i++) step(1'b1, 1'b0);
        for (int i = 0; i < lo; i++) step(1'b0, 1'b0);
    endtask

    // monitor: compare each cycle after the edge settles
    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            check(e.tag, q_out, e.cnt);
            check({e.tag, " carry"}, {3'b0, carry_out}, {3'b0, e.carry});
            // R5: weight-8 stage high only at 8 and 9
            check("R5", {3'b0, q_out[3]}, {3'b0, (e.cnt >= 8)});
            // R4: codes 10..15 never seen
            check("R4", {3'b0, (q_out > 4'd9)}, 4'd0);
        end
    end

    initial begin
        step(1'b1, 1'b1);
        step(1'b0, 1'b1);
        step(1'b1, 1'b1);
        // R8: eight counts from zero read as 4'b1000
        for (int k = 0; k < 8; k++) pulse(1, 1);
        @(negedge clk);
        check("R8", q_out, 4'b1000);
        for (int k = 0; k < 12; k++) pulse(1 + (k % 3), 1 + (k % 4));
        // R7: long high and long low holds
        pulse(20, 15);
        for (int k = 0; k < 4; k++) pulse(2, 1);
        // reach 9, then reset mid-count (R1)
        while (m_cnt != 9) pulse(1, 2);
        step(1'b1, 1'b1);
        step(1'b0, 1'b1);
        step(1'b0, 1'b0);
        for (int k = 0; k < 25; k++) pulse(1, 1);
        repeat (3) step(1'b0, 1'b0);
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_checks++;
                n_fail++;
                $display("FAIL watchdog actual=hung expected=done");
            end
        join_any
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule